// File: doc/BRIEF.md
# Parallel Multiply-Accumulate and Load Issue Controller

This block sits at the issue stage of a floating-point unit. It handles one combined instruction that does three things at once: it adds register R2 into accumulator R3, it multiplies two registers into a chosen destination, and it loads a 32-bit word from memory into another register. The block decodes the register fields and rejects illegal destination combinations. It sends the load result to the register file one cycle after issue. It sends the accumulate and product results two cycles after issue. It also updates the status flags and checks the instruction in the single delay slot for use of a register that is still pending.

The floating-point arithmetic is done outside this block. An external datapath supplies the sum, the product and their underflow and overflow indications during the delay-slot cycle, and the block only routes them. The memory address is also worked out elsewhere. The load data arrives together with the issued instruction word, and the upper byte of the high halfword (the addressing mode) is ignored. The instruction in the delay slot is described by three operand indices, and each index has its own use bit.

Top module: `mac_load_issue`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every write enable, both error outputs and all six flags read 0. `acc_addr` always reads 3.
- R2: An issue (`issue_valid` high) is recognised only when `instr[15:4]` equals 12'hE33. Any other word causes no write, no flag change and no error.
- R3: The fields sit at fixed positions. The first multiply source is `instr[3:1]`. The second multiply source is {`instr[23:22]`, `instr[0]`}. The multiply destination is `instr[21:19]`. The load destination is `instr[18:16]`. `instr[31:24]` is ignored.
- R4: The instruction is illegal when the load destination equals 3 or equals the multiply destination. In that case `illegal_err` is high for the one cycle after issue, no write of any kind follows, and the flags keep their values.
- R5: For a legal issue, in the cycle after issue, `ld_we` is high, `ld_addr` holds the load destination, and `ld_data` holds the `load_data` that was present at issue.
- R6: Two cycles after a legal issue, `acc_we` and `mul_we` are high together. `acc_addr` is 3, `mul_addr` is the multiply destination, and the data are the `sum_res` and `prod_res` sampled in the delay-slot cycle.
- R7: In the delay-slot cycle, if a slot operand with its use bit set equals 3 or the pending multiply destination, `hazard_err` rises together with the writes in R6. Operands whose use bit is clear are ignored, and the writes still take place.
- R8: When a legal load is written, `flag_nf` takes bit 31 and `flag_zf` is cleared. If bits 30:23 are all zero, `flag_zf` is set and `flag_nf` is cleared instead.
- R9: When a legal load is written, `flag_ni` takes bit 31, and `flag_zi` is set only if all 32 bits are zero.
- R10: `flag_luf` and `flag_lvf` are set, in the same cycle as the writes in R6, when the sum or the product reports underflow or overflow respectively. After that they stay set.
- R11: `clr_sticky` clears both sticky flags at the next edge. A set event on that same edge takes priority over the clear.
- R12: Issues may follow each other on consecutive cycles. Each one keeps its own timing for R5 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word presented this cycle |
| instr | input | 32 | Instruction word |
| load_data | input | DATA_W | Memory word for the load |
| sum_res | input | DATA_W | Accumulate result from the datapath (delay-slot cycle) |
| sum_uf | input | 1 | Underflow reported by the add |
| sum_of | input | 1 | Overflow reported by the add |
| prod_res | input | DATA_W | Product from the datapath (delay-slot cycle) |
| prod_uf | input | 1 | Underflow reported by the multiply |
| prod_of | input | 1 | Overflow reported by the multiply |
| slot_valid | input | 1 | Instruction present in the delay slot |
| slot_dst_en | input | 1 | Slot instruction writes a register |
| slot_dst | input | 3 | Slot destination index |
| slot_srca_en | input | 1 | Slot uses its first source |
| slot_srca | input | 3 | Slot first source index |
| slot_srcb_en | input | 1 | Slot uses its second source |
| slot_srcb | input | 3 | Slot second source index |
| clr_sticky | input | 1 | Clear the sticky underflow and overflow flags |
| ld_we | output | 1 | Load write enable |
| ld_addr | output | 3 | Load write index |
| ld_data | output | DATA_W | Load write data |
| acc_we | output | 1 | Accumulator write enable |
| acc_addr | output | 3 | Accumulator write index (always 3) |
| acc_data | output | DATA_W | Accumulator write data |
| mul_we | output | 1 | Product write enable |
| mul_addr | output | 3 | Product write index |
| mul_data | output | DATA_W | Product write data |
| flag_nf | output | 1 | Floating negative flag |
| flag_zf | output | 1 | Floating zero flag |
| flag_ni | output | 1 | Integer negative flag |
| flag_zi | output | 1 | Integer zero flag |
| flag_luf | output | 1 | Sticky underflow flag |
| flag_lvf | output | 1 | Sticky overflow flag |
| illegal_err | output | 1 | Illegal destination combination |
| hazard_err | output | 1 | Delay-slot register conflict |

## Verification
The directed cases cover these situations:
- One legal issue, with a conflict-free slot.
- Both illegal destination rules.
- A near-miss opcode.
- A slot conflict reached through each operand kind.
- Slot matches whose use bit is clear.
- Load words that are zero-exponent negative, all zero, or ordinary.
- Consecutive issues, which tell apart the per-issue writeback timing.

A sticky-flag sequence checks set, hold, clear, and set winning over clear on the same edge. Seeded random issues then mix legal and illegal field values, wrong opcodes and random slot operands. A bench model built from the requirements predicts every output each cycle, so a wrong field bit, a wrong latency or a missing suppression shows up as a mismatch.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int IDX_W    = 3;
  localparam int INSTR_W  = 32;
  localparam logic [11:0] OPC_VAL = 12'hE33;
  localparam logic [IDX_W-1:0] ACC_REG = 3'd3;

  typedef struct packed {
    logic             is_op;
    logic             bad_dst;
    logic [IDX_W-1:0] src_a;
    logic [IDX_W-1:0] src_b;
    logic [IDX_W-1:0] mul_dst;
    logic [IDX_W-1:0] ld_dst;
  } mlc_dec_t;
endpackage

// File: rtl/mlc_decode.sv
module mlc_decode
  import mlc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output mlc_dec_t           dec
);
  logic unused_mode_bits;
  assign unused_mode_bits = ^instr[31:24];

  always_comb begin
    dec.is_op   = (instr[15:4] == OPC_VAL);
    dec.src_a   = instr[3:1];
    dec.src_b   = {instr[23:22], instr[0]};
    dec.mul_dst = instr[21:19];
    dec.ld_dst  = instr[18:16];
    dec.bad_dst = (dec.ld_dst == ACC_REG) || (dec.ld_dst == dec.mul_dst);
  end
endmodule

// File: rtl/mlc_hazard.sv
module mlc_hazard
  import mlc_pkg::*;
#(
  parameter int N_OPS = 3
) (
  input  logic                        pend_valid,
  input  logic [IDX_W-1:0]            pend_mul_dst,
  input  logic                        slot_valid,
  input  logic [N_OPS-1:0]            op_en,
  input  logic [N_OPS-1:0][IDX_W-1:0] op_idx,
  output logic                        hit
);
  logic [N_OPS-1:0] match;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cmp
    assign match[i] = op_en[i] &&
                      ((op_idx[i] == ACC_REG) || (op_idx[i] == pend_mul_dst));
  end

  assign hit = pend_valid && slot_valid && (|match);
endmodule

// File: rtl/mlc_flags.sv
module mlc_flags #(
  parameter int DATA_W  = 32,
  parameter int EXP_LSB = 23,
  parameter int EXP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_upd,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              uf_evt,
  input  logic              of_evt,
  input  logic              clr,
  output logic              nf,
  output logic              zf,
  output logic              ni,
  output logic              zi,
  output logic              luf,
  output logic              lvf
);
  localparam int SIGN_BIT = DATA_W - 1;
  localparam int EXP_MSB  = EXP_LSB + EXP_W - 1;

  logic exp_zero;
  assign exp_zero = (ld_val[EXP_MSB:EXP_LSB] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      nf  <= 1'b0;
      zf  <= 1'b0;
      ni  <= 1'b0;
      zi  <= 1'b0;
      luf <= 1'b0;
      lvf <= 1'b0;
    end else begin
      if (ld_upd) begin
        nf <= ld_val[SIGN_BIT] && !exp_zero;
        zf <= exp_zero;
        ni <= ld_val[SIGN_BIT];
        zi <= (ld_val == '0);
      end
      luf <= (luf && !clr) || uf_evt;
      lvf <= (lvf && !clr) || of_evt;
    end
  end
endmodule

// File: rtl/mac_load_issue.sv
module mac_load_issue
  import mlc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int EXP_LSB = 23,
  parameter int EXP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] load_data,
  input  logic [DATA_W-1:0] sum_res,
  input  logic              sum_uf,
  input  logic              sum_of,
  input  logic [DATA_W-1:0] prod_res,
  input  logic              prod_uf,
  input  logic              prod_of,
  input  logic              slot_valid,
  input  logic              slot_dst_en,
  input  logic [2:0]        slot_dst,
  input  logic              slot_srca_en,
  input  logic [2:0]        slot_srca,
  input  logic              slot_srcb_en,
  input  logic [2:0]        slot_srcb,
  input  logic              clr_sticky,
  output logic              ld_we,
  output logic [2:0]        ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              acc_we,
  output logic [2:0]        acc_addr,
  output logic [DATA_W-1:0] acc_data,
  output logic              mul_we,
  output logic [2:0]        mul_addr,
  output logic [DATA_W-1:0] mul_data,
  output logic              flag_nf,
  output logic              flag_zf,
  output logic              flag_ni,
  output logic              flag_zi,
  output logic              flag_luf,
  output logic              flag_lvf,
  output logic              illegal_err,
  output logic              hazard_err
);
  localparam int N_SLOT_OPS = 3;

  mlc_dec_t dec;
  logic     go_op;
  logic     go_legal;
  logic     unused_src_bits;

  logic             pend_valid;
  logic [IDX_W-1:0] pend_dst;
  logic             haz_hit;

  logic [N_SLOT_OPS-1:0]            slot_en;
  logic [N_SLOT_OPS-1:0][IDX_W-1:0] slot_idx;

  mlc_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign unused_src_bits = ^{dec.src_a, dec.src_b};
  assign go_op    = issue_valid && dec.is_op;
  assign go_legal = go_op && !dec.bad_dst;

  // Load stage: retires one cycle after issue.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_we       <= 1'b0;
      ld_addr     <= '0;
      ld_data     <= '0;
      pend_valid  <= 1'b0;
      pend_dst    <= '0;
      illegal_err <= 1'b0;
    end else begin
      ld_we       <= go_legal;
      pend_valid  <= go_legal;
      illegal_err <= go_op && dec.bad_dst;
      if (go_legal) begin
        ld_addr  <= dec.ld_dst;
        ld_data  <= load_data;
        pend_dst <= dec.mul_dst;
      end
    end
  end

  assign slot_en  = {slot_srcb_en, slot_srca_en, slot_dst_en};
  assign slot_idx = {slot_srcb, slot_srca, slot_dst};

  mlc_hazard #(.N_OPS(N_SLOT_OPS)) u_haz (
    .pend_valid   (pend_valid),
    .pend_mul_dst (pend_dst),
    .slot_valid   (slot_valid),
    .op_en        (slot_en),
    .op_idx       (slot_idx),
    .hit          (haz_hit)
  );

  // Arithmetic stage: retires two cycles after issue.
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_we     <= 1'b0;
      acc_data   <= '0;
      mul_we     <= 1'b0;
      mul_addr   <= '0;
      mul_data   <= '0;
      hazard_err <= 1'b0;
    end else begin
      acc_we     <= pend_valid;
      mul_we     <= pend_valid;
      hazard_err <= haz_hit;
      if (pend_valid) begin
        acc_data <= sum_res;
        mul_addr <= pend_dst;
        mul_data <= prod_res;
      end
    end
  end

  assign acc_addr = ACC_REG;

  mlc_flags #(
    .DATA_W  (DATA_W),
    .EXP_LSB (EXP_LSB),
    .EXP_W   (EXP_W)
  ) u_flags (
    .clk    (clk),
    .rst    (rst),
    .ld_upd (go_legal),
    .ld_val (load_data),
    .uf_evt (pend_valid && (sum_uf || prod_uf)),
    .of_evt (pend_valid && (sum_of || prod_of)),
    .clr    (clr_sticky),
    .nf     (flag_nf),
    .zf     (flag_zf),
    .ni     (flag_ni),
    .zi     (flag_zi),
    .luf    (flag_luf),
    .lvf    (flag_lvf)
  );
endmodule

// File: rtl/mac_load_issue_chk.sv
module mac_load_issue_chk (
  input logic        clk,
  input logic        rst,
  input logic        issue_valid,
  input logic [31:0] instr,
  input logic        clr_sticky,
  input logic        ld_we,
  input logic [2:0]  ld_addr,
  input logic        acc_we,
  input logic [2:0]  acc_addr,
  input logic        mul_we,
  input logic        flag_nf,
  input logic        flag_zf,
  input logic        flag_luf,
  input logic        flag_lvf,
  input logic        illegal_err,
  input logic        hazard_err
);
  logic legal_in;
  assign legal_in = issue_valid && (instr[15:4] == 12'hE33) &&
                    (instr[18:16] != 3'd3) && (instr[18:16] != instr[21:19]);

  a_r5_load_next_cycle: assert property (@(posedge clk) disable iff (rst)
    legal_in |=> (ld_we && ld_addr == $past(instr[18:16])));

  a_r6_mac_after_load: assert property (@(posedge clk) disable iff (rst)
    ld_we |=> (acc_we && mul_we && acc_addr == 3'd3));

  a_r4_illegal_no_load: assert property (@(posedge clk) disable iff (rst)
    illegal_err |-> !ld_we);

  a_r4_illegal_no_mac: assert property (@(posedge clk) disable iff (rst)
    illegal_err |=> !acc_we);

  a_r7_hazard_with_mac: assert property (@(posedge clk) disable iff (rst)
    hazard_err |-> acc_we);

  a_r8_nf_zf_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(flag_nf && flag_zf));

  a_r10_luf_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_luf && !clr_sticky) |=> flag_luf);

  a_r10_lvf_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_lvf && !clr_sticky) |=> flag_lvf);
endmodule

bind mac_load_issue mac_load_issue_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .issue_valid (issue_valid),
  .instr       (instr),
  .clr_sticky  (clr_sticky),
  .ld_we       (ld_we),
  .ld_addr     (ld_addr),
  .acc_we      (acc_we),
  .acc_addr    (acc_addr),
  .mul_we      (mul_we),
  .flag_nf     (flag_nf),
  .flag_zf     (flag_zf),
  .flag_luf    (flag_luf),
  .flag_lvf    (flag_lvf),
  .illegal_err (illegal_err),
  .hazard_err  (hazard_err)
);

// File: tb/mac_load_issue_bench.sv
`timescale 1ns/1ps
module mac_load_issue_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic issue_valid = 1'b0;
  logic [31:0] instr = '0, load_data = '0, sum_res = '0, prod_res = '0;
  logic sum_uf = 0, sum_of = 0, prod_uf = 0, prod_of = 0;
  logic slot_valid = 0, slot_dst_en = 0, slot_srca_en = 0, slot_srcb_en = 0;
  logic [2:0] slot_dst = '0, slot_srca = '0, slot_srcb = '0;
  logic clr_sticky = 0;
  logic ld_we, acc_we, mul_we;
  logic [2:0] ld_addr, acc_addr, mul_addr;
  logic [31:0] ld_data, acc_data, mul_data;
  logic flag_nf, flag_zf, flag_ni, flag_zi, flag_luf, flag_lvf;
  logic illegal_err, hazard_err;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic e_ld_we, e_acc_we, e_mul_we, e_ill, e_haz;
  logic [2:0] e_ld_addr, e_mul_addr, e_pd;
  logic [31:0] e_ld_data, e_acc_data, e_mul_data;
  logic e_nf, e_zf, e_ni, e_zi, e_luf, e_lvf, e_pv;

  always #2.5 clk = ~clk;

  mac_load_issue u_mac_load_issue (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .load_data(load_data), .sum_res(sum_res), .sum_uf(sum_uf), .sum_of(sum_of),
    .prod_res(prod_res), .prod_uf(prod_uf), .prod_of(prod_of),
    .slot_valid(slot_valid), .slot_dst_en(slot_dst_en), .slot_dst(slot_dst),
    .slot_srca_en(slot_srca_en), .slot_srca(slot_srca),
    .slot_srcb_en(slot_srcb_en), .slot_srcb(slot_srcb),
    .clr_sticky(clr_sticky), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_data(acc_data),
    .mul_we(mul_we), .mul_addr(mul_addr), .mul_data(mul_data),
    .flag_nf(flag_nf), .flag_zf(flag_zf), .flag_ni(flag_ni), .flag_zi(flag_zi),
    .flag_luf(flag_luf), .flag_lvf(flag_lvf),
    .illegal_err(illegal_err), .hazard_err(hazard_err)
  );

  function automatic logic [31:0] mk(input logic [2:0] fa, input logic [2:0] fb,
                                     input logic [2:0] d, input logic [2:0] a,
                                     input logic [7:0] mode);
    return {mode, fb[2:1], d, a, 12'hE33, fa, fb[0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    e_ld_we = 0; e_acc_we = 0; e_mul_we = 0; e_ill = 0; e_haz = 0;
    e_nf = 0; e_zf = 0; e_ni = 0; e_zi = 0; e_luf = 0; e_lvf = 0; e_pv = 0;
    e_pd = 0; e_ld_addr = 0; e_mul_addr = 0;
    e_ld_data = 0; e_acc_data = 0; e_mul_data = 0;
  endtask

  task automatic step(input string tag);
    logic op, bad, legal, hit;
    logic [2:0] a, d;
    op = issue_valid && instr[15:4] == 12'hE33;
    a = instr[18:16]; d = instr[21:19];
    bad = (a == 3'd3) || (a == d);
    legal = op && !bad;
    hit = e_pv && slot_valid &&
          ((slot_dst_en && (slot_dst == 3'd3 || slot_dst == e_pd)) ||
           (slot_srca_en && (slot_srca == 3'd3 || slot_srca == e_pd)) ||
           (slot_srcb_en && (slot_srcb == 3'd3 || slot_srcb == e_pd)));
    e_acc_we = e_pv; e_mul_we = e_pv; e_haz = hit;
    if (e_pv) begin e_acc_data = sum_res; e_mul_data = prod_res; e_mul_addr = e_pd; end
    e_luf = (e_luf && !clr_sticky) || (e_pv && (sum_uf || prod_uf));
    e_lvf = (e_lvf && !clr_sticky) || (e_pv && (sum_of || prod_of));
    e_ld_we = legal; e_ill = op && bad;
    if (legal) begin
      e_ld_addr = a; e_ld_data = load_data;
      e_zf = (load_data[30:23] == 8'd0);
      e_nf = load_data[31] && !e_zf;
      e_ni = load_data[31];
      e_zi = (load_data == 32'd0);
      e_pd = d;
    end
    e_pv = legal;
    @(posedge clk); #1;
    chk({tag, "/R5"}, "ld_we", ld_we, e_ld_we);
    if (e_ld_we) begin
      chk({tag, "/R5"}, "ld_addr", ld_addr, e_ld_addr);
      chk({tag, "/R5"}, "ld_data", ld_data, e_ld_data);
    end
    chk({tag, "/R6"}, "acc_we", acc_we, e_acc_we);
    chk({tag, "/R6"}, "mul_we", mul_we, e_mul_we);
    chk({tag, "/R6"}, "acc_addr", acc_addr, 3);
    if (e_acc_we) begin
      chk({tag, "/R6"}, "acc_data", acc_data, e_acc_data);
      chk({tag, "/R6"}, "mul_addr", mul_addr, e_mul_addr);
      chk({tag, "/R6"}, "mul_data", mul_data, e_mul_data);
    end
    chk({tag, "/R4"}, "illegal_err", illegal_err, e_ill);
    chk({tag, "/R7"}, "hazard_err", hazard_err, e_haz);
    chk({tag, "/R8"}, "nf", flag_nf, e_nf);
    chk({tag, "/R8"}, "zf", flag_zf, e_zf);
    chk({tag, "/R9"}, "ni", flag_ni, e_ni);
    chk({tag, "/R9"}, "zi", flag_zi, e_zi);
    chk({tag, "/R10"}, "luf", flag_luf, e_luf);
    chk({tag, "/R10"}, "lvf", flag_lvf, e_lvf);
  endtask

  task automatic quiet();
    issue_valid = 0; slot_valid = 0; clr_sticky = 0;
    sum_uf = 0; sum_of = 0; prod_uf = 0; prod_of = 0;
  endtask

  task automatic slot(input logic de, input logic [2:0] dv, input logic ae,
                      input logic [2:0] av, input logic be, input logic [2:0] bv);
    slot_valid = 1; slot_dst_en = de; slot_dst = dv;
    slot_srca_en = ae; slot_srca = av; slot_srcb_en = be; slot_srcb = bv;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "ld_we", ld_we, 0); chk("R1", "acc_we", acc_we, 0);
    chk("R1", "mul_we", mul_we, 0); chk("R1", "acc_addr", acc_addr, 3);
    chk("R1", "illegal_err", illegal_err, 0); chk("R1", "hazard_err", hazard_err, 0);
    chk("R1", "flags", {flag_nf, flag_zf, flag_ni, flag_zi, flag_luf, flag_lvf}, 0);
    rst = 0;
    quiet(); step("R1");

    // R3/R5/R6: legal issue, second source split across halfwords, clean slot
    issue_valid = 1; instr = mk(3'd1, 3'd6, 3'd5, 3'd4, 8'hA5);
    load_data = 32'h4049_0FDB; step("R3");
    quiet(); slot(1, 3'd0, 1, 3'd1, 1, 3'd2);
    sum_res = 32'h1111_2222; prod_res = 32'h3333_4444; step("R6");
    quiet(); step("R6");

    // R4: load destination is the accumulator, then equals multiply dest
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd2, 3'd3, 8'h00);
    load_data = 32'h8000_0001; step("R4");
    quiet(); step("R4"); step("R4");
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd6, 3'd6, 8'h00); step("R4");
    quiet(); step("R4"); step("R4");

    // R2: near-miss opcode
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd5, 3'd4, 8'h00) ^ 32'h0000_0010;
    step("R2"); quiet(); step("R2"); step("R2");

    // R7: slot destination hits accumulator
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd5, 3'd4, 8'h00); load_data = 32'h0;
    step("R9");
    quiet(); slot(1, 3'd3, 0, 3'd0, 0, 3'd0); step("R7"); quiet(); step("R7");
    // R7: slot source b hits multiply destination
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd2, 3'd7, 8'h00); load_data = 32'h807F_FFFF;
    step("R8");
    quiet(); slot(0, 3'd0, 0, 3'd0, 1, 3'd2); step("R7"); quiet(); step("R7");
    // R7: matches present but use bits clear
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd2, 3'd7, 8'h00); load_data = 32'hC000_0000;
    step("R8");
    quiet(); slot(0, 3'd3, 0, 3'd2, 0, 3'd3); step("R7"); quiet(); step("R7");

    // R10/R11: sticky behaviour
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd5, 3'd4, 8'h00); step("R10");
    quiet(); prod_of = 1; sum_uf = 1; step("R10");
    quiet(); step("R10"); step("R10");
    clr_sticky = 1; step("R11"); quiet(); step("R11");
    issue_valid = 1; instr = mk(3'd0, 3'd1, 3'd5, 3'd4, 8'h00); step("R11");
    quiet(); clr_sticky = 1; sum_of = 1; step("R11"); quiet(); step("R11");

    // R12: back-to-back issues
    for (int i = 0; i < 4; i++) begin
      issue_valid = 1; instr = mk(3'(i), 3'(i + 1), 3'(i + 4), 3'(i), 8'h3C);
      if (i == 3) instr = mk(3'd0, 3'd0, 3'd7, 3'd6, 8'h00);
      load_data = 32'h1000_0000 * i; sum_res = 32'hA000_0000 + i;
      prod_res = 32'hB000_0000 + i;
      step("R12");
    end
    quiet(); step("R12"); step("R12");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      issue_valid = ($urandom % 10) < 7;
      instr = $urandom;
      if (($urandom % 10) != 0) instr[15:4] = 12'hE33;
      load_data = $urandom;
      if (($urandom % 8) == 0) load_data[30:23] = 8'd0;
      if (($urandom % 16) == 0) load_data = 32'd0;
      sum_res = $urandom; prod_res = $urandom;
      sum_uf = ($urandom % 16) == 0; sum_of = ($urandom % 16) == 0;
      prod_uf = ($urandom % 16) == 0; prod_of = ($urandom % 16) == 0;
      clr_sticky = ($urandom % 8) == 0;
      slot(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom),
           1'($urandom), 3'($urandom));
      slot_valid = 1'($urandom);
      step("R12");
    end
    quiet(); step("R2"); step("R2");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule